// File: doc/BRIEF.md
# Dual Alarm Match Interrupt Unit

This block watches the running time fields of a real-time clock and compares them with two independent alarm settings. Each alarm has one compare value per time field and one enable bit per field, so a field can be left out of the comparison. A comparison is taken only on the one-cycle seconds tick that the timekeeping logic supplies. When every enabled field of an armed alarm agrees with the time, that alarm raises its own status flag. It also asserts an active-low interrupt line that both alarms share.

A mode input chooses how the interrupt behaves. In latched mode, the line goes low on a match and stays low until software reads the status. Each alarm also fires only once, until software clears its enable bit and sets it again. In pulsed mode, every match drives the line low for a fixed number of clock cycles and then releases it, with no read needed. While the frequency-output enable is high, the pin serves another purpose. The interrupt is then kept released and no interrupt state is started, but the flags keep working. A status-read strobe clears both flags and the latched interrupt together.

Top module: `alarm_irq_unit`

## Requirements
- R1: Alarm k matches when tick_i is 1, alm_en_i[k] is 1, the alarm is armed, and every field f whose bit alm_fen_i[k][f] is 1 has time_i[f*FIELD_W +: FIELD_W] equal to alm_val_i[k][f*FIELD_W +: FIELD_W]. A field whose enable bit is 0 always counts as equal. Without tick_i there is no match, and an alarm whose alm_en_i bit is 0 never matches.
- R2: A match of alarm k sets flag_o[k] at the next clock edge. This happens in either mode and whatever the value of fout_en_i.
- R3: A cycle in which sr_read_i is 1 clears both flags and the latched interrupt at the next edge.
- R4: When a match and sr_read_i fall in the same cycle, the match wins. The flag of the matching alarm reads 1 afterwards, and in latched mode irq_no stays 0.
- R5: When pulse_mode_i is 0 (latched mode) and fout_en_i is 0, a match drives irq_no to 0 from the next cycle. irq_no then stays 0 until the cycle after an sr_read_i strobe.
- R6: Either alarm on its own drives the shared irq_no.
- R7: In latched mode, an alarm that has matched is disarmed and ignores later matches. It is armed again after any cycle in which its alm_en_i bit is 0.
- R8: When pulse_mode_i is 1 and fout_en_i is 0, a match drives irq_no to 0 for exactly PULSE_CYC cycles (default 4) and then releases it. A match during a pulse restarts the count, and sr_read_i has no effect on the pulse.
- R9: While fout_en_i is 1, irq_no is 1, and a match neither latches the interrupt nor starts a pulse. The flags still follow R2 and R3.
- R10: After reset, both flags are 0, irq_no is 1 and both alarms are armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle seconds tick, the compare strobe |
| time_i | input | N_FIELDS*FIELD_W | Current time fields, field f at bits f*FIELD_W upward |
| alm_val_i | input | 2 x N_FIELDS*FIELD_W | Compare values for each alarm |
| alm_fen_i | input | 2 x N_FIELDS | Per-field compare enables for each alarm |
| alm_en_i | input | 2 | Enable for each alarm |
| pulse_mode_i | input | 1 | 0 selects latched interrupt, 1 selects pulsed interrupt |
| fout_en_i | input | 1 | Frequency output enabled; suppresses the alarm interrupt |
| sr_read_i | input | 1 | Status-read strobe that clears the flags |
| flag_o | output | 2 | Alarm occurred flags |
| irq_no | output | 1 | Shared interrupt, active low |

## Verification
Two events can land on the same edge: an alarm match that sets a flag, and a status read that clears it. The same holds for the latched interrupt, which a match sets and a read releases. The random phase raises the read strobe on about one cycle in eight while ticks and narrow field values make matches frequent, so the two often coincide. A directed case forces a match and a read into one cycle. A cycle-by-cycle reference model applies the match-wins rule and judges the result at the flags and at irq_no.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int unsigned N_ALM = 2;

  typedef enum logic {
    IRQ_LATCHED = 1'b0,
    IRQ_PULSED  = 1'b1
  } irq_mode_e;
endpackage

// File: rtl/alarm_match.sv
module alarm_match #(
  parameter int unsigned N_FIELDS = 6,
  parameter int unsigned FIELD_W  = 8
) (
  input  logic [N_FIELDS*FIELD_W-1:0] time_i,
  input  logic [N_FIELDS*FIELD_W-1:0] val_i,
  input  logic [N_FIELDS-1:0]         fen_i,
  output logic                        eq_o
);
  logic [N_FIELDS-1:0] field_ok;

  for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
    // disabled field is a wildcard
    assign field_ok[f] = !fen_i[f] ||
                         (time_i[f*FIELD_W +: FIELD_W] == val_i[f*FIELD_W +: FIELD_W]);
  end

  assign eq_o = &field_ok;
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  input  logic eq_i,
  input  logic single_i,
  input  logic sr_read_i,
  output logic hit_o,
  output logic flag_o
);
  logic flag_q, armed_q;

  assign hit_o  = tick_i && en_i && armed_q && eq_i;
  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (hit_o) begin
      flag_q <= 1'b1;          // set wins over read
    end else if (sr_read_i) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
    end else if (!en_i) begin
      armed_q <= 1'b1;
    end else if (hit_o && single_i) begin
      armed_q <= 1'b0;
    end
  end

  assert_flag_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> flag_q);
  assert_flag_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(hit_o));
  assert_flag_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_read_i && !hit_o |=> !flag_q);
  assert_one_shot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && single_i |=> !hit_o);
  assert_rearm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> armed_q);
endmodule

// File: rtl/alarm_irq.sv
module alarm_irq
  import alarm_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ALM-1:0] hit_i,
  input  irq_mode_e        mode_i,
  input  logic             fout_en_i,
  input  logic             sr_read_i,
  output logic             irq_no
);
  localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1);

  logic             any_hit, set_latch, load_pulse, latch_q;
  logic [CNT_W-1:0] cnt_q;

  assign any_hit    = |hit_i;
  assign set_latch  = any_hit && (mode_i == IRQ_LATCHED) && !fout_en_i;
  assign load_pulse = any_hit && (mode_i == IRQ_PULSED) && !fout_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b0;
    end else if (set_latch) begin
      latch_q <= 1'b1;
    end else if (sr_read_i) begin
      latch_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_pulse) begin
      cnt_q <= CNT_W'(PULSE_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // pin taken by frequency output: interrupt released
  assign irq_no = fout_en_i || !(latch_q || (cnt_q != '0));

  assert_latch_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_latch |=> latch_q);
  assert_latch_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_q && !sr_read_i |=> latch_q);
  assert_pulse_len_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) && !load_pulse |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  assert_pulse_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_pulse |=> cnt_q == CNT_W'(PULSE_CYC));
  assert_quiet_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fout_en_i && (cnt_q == '0) |=> cnt_q == '0);
  assert_quiet_latch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fout_en_i && !latch_q |=> !latch_q);
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
  import alarm_pkg::*;
#(
  parameter int unsigned N_FIELDS  = 6,
  parameter int unsigned FIELD_W   = 8,
  parameter int unsigned PULSE_CYC = 4
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  tick_i,
  input  logic [N_FIELDS*FIELD_W-1:0]           time_i,
  input  logic [N_ALM-1:0][N_FIELDS*FIELD_W-1:0] alm_val_i,
  input  logic [N_ALM-1:0][N_FIELDS-1:0]        alm_fen_i,
  input  logic [N_ALM-1:0]                      alm_en_i,
  input  logic                                  pulse_mode_i,
  input  logic                                  fout_en_i,
  input  logic                                  sr_read_i,
  output logic [N_ALM-1:0]                      flag_o,
  output logic                                  irq_no
);
  logic [N_ALM-1:0] eq, hit;
  irq_mode_e        mode;

  assign mode = pulse_mode_i ? IRQ_PULSED : IRQ_LATCHED;

  for (genvar a = 0; a < N_ALM; a++) begin : g_alarm
    alarm_match #(
      .N_FIELDS (N_FIELDS),
      .FIELD_W  (FIELD_W)
    ) i_match (
      .time_i (time_i),
      .val_i  (alm_val_i[a]),
      .fen_i  (alm_fen_i[a]),
      .eq_o   (eq[a])
    );

    alarm_flag i_flag (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .en_i      (alm_en_i[a]),
      .eq_i      (eq[a]),
      .single_i  (mode == IRQ_LATCHED),
      .sr_read_i (sr_read_i),
      .hit_o     (hit[a]),
      .flag_o    (flag_o[a])
    );
  end

  alarm_irq #(
    .PULSE_CYC (PULSE_CYC)
  ) i_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit),
    .mode_i    (mode),
    .fout_en_i (fout_en_i),
    .sr_read_i (sr_read_i),
    .irq_no    (irq_no)
  );

  assert_irq_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_no) && !$past(fout_en_i) && !fout_en_i |-> $past(|hit));
endmodule

// File: tb/test_alarm_irq_unit.sv
module test_alarm_irq_unit;
  localparam int NF = 6;
  localparam int FW = 8;
  localparam int PC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [NF*FW-1:0] tim = '0;
  logic [1:0][NF*FW-1:0] aval = '0;
  logic [1:0][NF-1:0] afen = '0;
  logic [1:0] aen = '0;
  logic pmode = 1'b0, fout = 1'b0, srd = 1'b0;
  logic [1:0] flag;
  logic irq_n;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference state
  logic [1:0] m_flag = '0, m_armed = 2'b11;
  logic m_latch = 1'b0;
  int m_cnt = 0;

  always #5 clk = ~clk;

  alarm_irq_unit #(.N_FIELDS(NF), .FIELD_W(FW), .PULSE_CYC(PC)) i_alarm_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .time_i(tim),
    .alm_val_i(aval), .alm_fen_i(afen), .alm_en_i(aen),
    .pulse_mode_i(pmode), .fout_en_i(fout), .sr_read_i(srd),
    .flag_o(flag), .irq_no(irq_n)
  );

  function automatic logic fields_eq(int a);
    for (int f = 0; f < NF; f++)
      if (afen[a][f] && tim[f*FW +: FW] != aval[a][f*FW +: FW]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic exp_irq();
    return fout || !(m_latch || m_cnt > 0);
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [1:0] m;
    for (int a = 0; a < 2; a++) m[a] = tick && aen[a] && m_armed[a] && fields_eq(a);
    for (int a = 0; a < 2; a++) begin
      if (m[a]) m_flag[a] = 1'b1; else if (srd) m_flag[a] = 1'b0;
      if (!aen[a]) m_armed[a] = 1'b1; else if (m[a] && !pmode) m_armed[a] = 1'b0;
    end
    if ((|m) && !pmode && !fout) m_latch = 1'b1; else if (srd) m_latch = 1'b0;
    if ((|m) && pmode && !fout) m_cnt = PC; else if (m_cnt > 0) m_cnt--;
  endtask

  // one clock: inputs already set at negedge; model at posedge; compare at next negedge
  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("R2 flag0", flag[0], m_flag[0]);
    check("R2 flag1", flag[1], m_flag[1]);
    check("R5/R8 irq", irq_n, exp_irq());
  endtask

  task automatic idle();
    tick = 1'b0; srd = 1'b0;
  endtask

  task automatic set_field(int a, int f, int v);
    aval[a][f*FW +: FW] = FW'(v);
    afen[a][f] = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED1);
    repeat (3) @(negedge clk);
    check("R10 flag0", flag[0], 1'b0);
    check("R10 flag1", flag[1], 1'b0);
    check("R10 irq", irq_n, 1'b1);
    rst_n = 1'b1;

    // R1: field match with wildcard, latched mode, alarm 0
    aen = 2'b01; afen = '0;
    set_field(0, 0, 7); set_field(0, 2, 3);
    tim = '0; tim[0 +: FW] = 8'd7; tim[2*FW +: FW] = 8'd3; tim[FW +: FW] = 8'd99;
    cyc(); check("R1 no tick", flag[0], 1'b0);
    tick = 1'b1; cyc(); idle();
    check("R1 match", flag[0], 1'b1);
    check("R5 irq low", irq_n, 1'b0);
    repeat (3) cyc();
    check("R5 irq held", irq_n, 1'b0);
    // R7: further tick while disarmed
    srd = 1'b1; cyc(); idle();
    check("R3 read flag", flag[0], 1'b0);
    check("R3 read irq", irq_n, 1'b1);
    tick = 1'b1; cyc(); idle();
    check("R7 disarmed", flag[0], 1'b0);
    aen = 2'b00; cyc(); aen = 2'b01;
    tick = 1'b1; cyc(); idle();
    check("R7 rearmed", flag[0], 1'b1);
    // R4: read and match together; needs rearm first
    aen = 2'b00; cyc(); aen = 2'b01;
    tick = 1'b1; srd = 1'b1; cyc(); idle();
    check("R4 flag kept", flag[0], 1'b1);
    check("R4 irq kept", irq_n, 1'b0);
    srd = 1'b1; cyc(); idle();

    // R6: alarm 1 alone drives irq
    aen = 2'b10; afen[1] = '0; set_field(1, 5, 42);
    tim[5*FW +: FW] = 8'd42;
    tick = 1'b1; cyc(); idle();
    check("R6 flag1", flag[1], 1'b1);
    check("R6 flag0 idle", flag[0], 1'b0);
    check("R6 irq", irq_n, 1'b0);
    srd = 1'b1; cyc(); idle();
    check("R1 disabled alarm", flag[0], 1'b0);

    // R8: pulsed mode width and read immunity
    pmode = 1'b1; aen = 2'b00; cyc(); aen = 2'b10;
    tick = 1'b1; cyc(); idle();
    for (int i = 0; i < PC; i++) begin
      check("R8 pulse low", irq_n, 1'b0);
      srd = (i == 1); cyc(); idle();
    end
    check("R8 pulse end", irq_n, 1'b1);
    tick = 1'b1; cyc(); idle();
    cyc(); tick = 1'b1; cyc(); idle();
    check("R8 retrigger", irq_n, 1'b0);
    repeat (PC - 1) cyc();
    check("R8 retrigger low", irq_n, 1'b0);
    cyc();
    check("R8 retrigger end", irq_n, 1'b1);

    // R9: frequency output suppresses irq, flags still set
    srd = 1'b1; cyc(); idle();
    fout = 1'b1; pmode = 1'b0;
    tick = 1'b1; cyc(); idle();
    check("R9 flag", flag[1], 1'b1);
    check("R9 irq", irq_n, 1'b1);
    fout = 1'b0; cyc();
    check("R9 no latch", irq_n, 1'b1);
    srd = 1'b1; cyc(); idle();

    // random phase
    for (int i = 0; i < 4000; i++) begin
      tick = $urandom_range(1, 0) == 1;
      srd = $urandom_range(7, 0) == 0;
      for (int f = 0; f < NF; f++) tim[f*FW +: FW] = FW'($urandom_range(1, 0));
      if ($urandom_range(15, 0) == 0) begin
        for (int a = 0; a < 2; a++) begin
          afen[a] = NF'($urandom);
          for (int f = 0; f < NF; f++) aval[a][f*FW +: FW] = FW'($urandom_range(1, 0));
        end
      end
      aen = ($urandom_range(9, 0) == 0) ? 2'($urandom) : 2'b11;
      if ($urandom_range(31, 0) == 0) pmode = ~pmode;
      fout = $urandom_range(15, 0) == 0;
      cyc();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule